// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block is the coherence side of one private write-back cache on a shared snooping bus. It holds a small direct-mapped array of line states and tags, each line being Invalid, Shared, Exclusive or Modified. The processor side takes one request at a time: read, write or replace. To serve a request it may place a single bus command on the bus and wait for a grant. A read miss fills the line as Exclusive when no other cache claims a copy and as Shared when one does. Writes to Exclusive or Modified lines complete without bus traffic, and writes to Shared lines use a data-less upgrade.

The snoop side watches the commands that other caches are granted. For each one it answers in the same cycle with two signals: a shared claim, which is ORed into the requester's shared input, and a flush request for dirty data. In the following cycle it demotes or invalidates the local copy. If a request lands on an index whose line belongs to another address, the controller first evicts that line, with a write-back when it is dirty, and then serves the request. Data storage, memory and arbitration live outside the block.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is 1, `cpu_done` is 0 and `bus_cmd` is 0 (none). Line states are reported on `cpu_state` as 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
- R2: A read of a line that is not present drives `bus_cmd` = 1 (read). In the cycle `bus_gnt` is high, `shared_in` is sampled: 1 fills the line as Shared, 0 fills it as Exclusive.
- R3: A read that hits a Shared, Exclusive or Modified line drives no bus command, and the line keeps its state. `bus_cmd` is 0 whenever `cpu_ready` is 1.
- R4: A write ends with the line Modified. From Invalid it drives `bus_cmd` = 2 (read-exclusive), from Shared it drives 3 (upgrade), and from Exclusive or Modified it drives nothing.
- R5: A snooped read (`snoop_cmd` = 1) that hits a valid line raises `snoop_shared` in the same cycle. It moves Exclusive and Modified lines to Shared, and a Modified line also raises `snoop_flush`.
- R6: A snooped read-exclusive (2) or upgrade (3) that hits a valid line makes it Invalid. A Modified line raises `snoop_flush` in that cycle. `snoop_flush` is never high without a snoop.
- R7: A replace of a Modified line drives `bus_cmd` = 4 (write-back) and leaves the line Invalid. A replace of an Exclusive, Shared or absent line is silent and reports Invalid.
- R8: A read or write whose index holds a valid line with a different tag first evicts that line. A Modified victim is written back with `bus_cmd` = 4 and the victim's address on `bus_addr`, and a clean victim is dropped silently. The request is then served as a miss.
- R9: A snoop whose tag differs from the stored tag, or which finds the line Invalid, raises neither `snoop_shared` nor `snoop_flush` and changes nothing. A snooped write-back (4) changes nothing.
- R10: Until it is granted, a pending bus command and its address stay stable from cycle to cycle, except in a cycle in which a snoop arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 read, 1 write, 2 replace |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | One-cycle pulse when a request completes |
| cpu_state | output | 2 | Line state after the completed request |
| bus_cmd | output | 3 | Command asked for: 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Line address of the command |
| bus_gnt | input | 1 | The command is on the bus in this cycle |
| shared_in | input | 1 | Wired-OR shared claim from the other caches |
| snoop_valid | input | 1 | Another cache's command is on the bus |
| snoop_cmd | input | 3 | That command, same encoding as `bus_cmd` |
| snoop_addr | input | ADDR_W | That command's line address |
| snoop_flush | output | 1 | Local dirty copy must supply the data |
| snoop_shared | output | 1 | Local valid copy exists, claimed on a snooped read |

## Verification
The assertions rely on the arbiter never granting this cache while one of its own commands is absent, and never raising `bus_gnt` together with `snoop_valid`, because the bus carries one command per cycle. The bench meets this by wiring two controllers back to back. A grant is given only to a cache whose `bus_cmd` is non-zero, and the other cache's snoop inputs are driven from the granted command, so the granted cache never sees a snoop. It also holds each request until the previous one has completed, and uses only the three defined operation codes.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDX  = 3'd2,
        CMD_UPGR = 3'd3,
        CMD_WB   = 3'd4
    } bus_cmd_t;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_RP  = 2'd2,
        OP_RSV = 2'd3
    } cpu_op_t;

    // Commands from another cache that act on a local copy.
    function automatic logic snoop_acts(input bus_cmd_t c);
        return (c == CMD_RD) || (c == CMD_RDX) || (c == CMD_UPGR);
    endfunction

    // State after a snooped command hits a valid copy.
    function automatic line_st_t snoop_next(input line_st_t s, input bus_cmd_t c);
        line_st_t n;
        n = s;
        if (c == CMD_RD)
            n = ST_S;
        else if ((c == CMD_RDX) || (c == CMD_UPGR))
            n = ST_I;
        return n;
    endfunction

    // Bus command a write needs, given the current line state.
    function automatic bus_cmd_t write_cmd(input line_st_t s);
        bus_cmd_t c;
        case (s)
            ST_I:    c = CMD_RDX;
            ST_S:    c = CMD_UPGR;
            default: c = CMD_NONE;
        endcase
        return c;
    endfunction

    // Fill state of a read miss, chosen by the sampled shared line.
    function automatic line_st_t read_fill(input logic shared);
        return shared ? ST_S : ST_E;
    endfunction

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 9
) (
    input  logic              clk,
    input  logic              rst,
    // read port for the request side
    input  logic [INDEX_W-1:0] ra_idx,
    output line_st_t           ra_st,
    output logic [TAG_W-1:0]   ra_tag,
    // read port for the snoop side
    input  logic [INDEX_W-1:0] rb_idx,
    output line_st_t           rb_st,
    output logic [TAG_W-1:0]   rb_tag,
    // write port from the request side (state and tag)
    input  logic               pw_en,
    input  logic [INDEX_W-1:0] pw_idx,
    input  line_st_t           pw_st,
    input  logic [TAG_W-1:0]   pw_tag,
    // write port from the snoop side (state only)
    input  logic               sw_en,
    input  logic [INDEX_W-1:0] sw_idx,
    input  line_st_t           sw_st
);

    localparam int LINES = 1 << INDEX_W;

    line_st_t         st_r  [LINES];
    logic [TAG_W-1:0] tag_r [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_r[g]  <= ST_I;
                tag_r[g] <= '0;
            end else if (pw_en && (pw_idx == INDEX_W'(g))) begin
                st_r[g]  <= pw_st;
                tag_r[g] <= pw_tag;
            end else if (sw_en && (sw_idx == INDEX_W'(g))) begin
                st_r[g]  <= sw_st;
            end
        end
    end

    assign ra_st  = st_r[ra_idx];
    assign ra_tag = tag_r[ra_idx];
    assign rb_st  = st_r[rb_idx];
    assign rb_tag = tag_r[rb_idx];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 9
) (
    input  logic               snoop_valid,
    input  bus_cmd_t           snoop_cmd,
    input  logic [TAG_W-1:0]   snoop_tag,
    input  logic [INDEX_W-1:0] snoop_idx,
    input  line_st_t           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    output logic               flush,
    output logic               shared,
    output logic               sw_en,
    output logic [INDEX_W-1:0] sw_idx,
    output line_st_t           sw_st
);

    logic hit;
    logic acts;

    always_comb begin
        hit    = snoop_valid && (line_st != ST_I) && (line_tag == snoop_tag);
        acts   = hit && snoop_acts(snoop_cmd);
        flush  = acts && (line_st == ST_M);
        shared = hit && (snoop_cmd == CMD_RD);
        sw_en  = acts;
        sw_idx = snoop_idx;
        sw_st  = snoop_next(line_st, snoop_cmd);
    end

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int INDEX_W = 3,
    localparam int TAG_W  = ADDR_W - INDEX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  cpu_op_t            cpu_op,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               cpu_ready,
    output logic               cpu_done,
    output line_st_t           cpu_state,
    output bus_cmd_t           bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_gnt,
    input  logic               shared_in,
    input  logic               snoop_same,
    output logic [INDEX_W-1:0] req_idx,
    input  line_st_t           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    output logic               pw_en,
    output line_st_t           pw_st,
    output logic [TAG_W-1:0]   pw_tag
);

    typedef enum logic {P_IDLE, P_BUSY} phase_t;

    phase_t            ph_q;
    cpu_op_t           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    line_st_t          res_q;

    logic [TAG_W-1:0]  req_tag;
    logic              present;
    logic              hit;
    logic              finish;
    line_st_t          fin_st;

    assign req_idx   = addr_q[INDEX_W-1:0];
    assign req_tag   = addr_q[ADDR_W-1:INDEX_W];
    assign cpu_ready = (ph_q == P_IDLE);
    assign cpu_done  = done_q;
    assign cpu_state = res_q;

    always_comb begin
        present  = (line_st != ST_I);
        hit      = present && (line_tag == req_tag);
        bus_cmd  = CMD_NONE;
        bus_addr = addr_q;
        pw_en    = 1'b0;
        pw_st    = ST_I;
        pw_tag   = req_tag;
        finish   = 1'b0;
        fin_st   = ST_I;

        if (ph_q == P_BUSY) begin
            if (op_q == OP_RP) begin
                if (hit && (line_st == ST_M)) begin
                    bus_cmd = CMD_WB;
                    if (bus_gnt) begin
                        pw_en  = 1'b1;
                        finish = 1'b1;
                    end
                end else if (!snoop_same) begin
                    pw_en  = hit;
                    finish = 1'b1;
                end
            end else if (present && !hit) begin
                // another address owns the index: evict it first
                pw_tag = line_tag;
                if (line_st == ST_M) begin
                    bus_cmd  = CMD_WB;
                    bus_addr = {line_tag, req_idx};
                    pw_en    = bus_gnt;
                end else begin
                    pw_en = !snoop_same;
                end
            end else if (op_q == OP_WR) begin
                bus_cmd = write_cmd(line_st);
                fin_st  = ST_M;
                pw_st   = ST_M;
                if (bus_cmd != CMD_NONE) begin
                    pw_en  = bus_gnt;
                    finish = bus_gnt;
                end else if (!snoop_same) begin
                    pw_en  = 1'b1;
                    finish = 1'b1;
                end
            end else begin
                // read, and the reserved code served as a read
                if (!present) begin
                    bus_cmd = CMD_RD;
                    pw_st   = read_fill(shared_in);
                    fin_st  = pw_st;
                    pw_en   = bus_gnt;
                    finish  = bus_gnt;
                end else if (!snoop_same) begin
                    fin_st = line_st;
                    finish = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= P_IDLE;
            op_q   <= OP_RD;
            addr_q <= '0;
            done_q <= 1'b0;
            res_q  <= ST_I;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                P_IDLE: begin
                    if (cpu_valid) begin
                        op_q   <= cpu_op;
                        addr_q <= cpu_addr;
                        ph_q   <= P_BUSY;
                    end
                end
                default: begin
                    if (finish) begin
                        done_q <= 1'b1;
                        res_q  <= fin_st;
                        ph_q   <= P_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int INDEX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [1:0]        cpu_state,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              shared_in,
    input  logic              snoop_valid,
    input  logic [2:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_flush,
    output logic              snoop_shared
);

    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] req_idx;
    line_st_t           ra_st;
    logic [TAG_W-1:0]   ra_tag;
    line_st_t           rb_st;
    logic [TAG_W-1:0]   rb_tag;
    logic               pw_en;
    line_st_t           pw_st;
    logic [TAG_W-1:0]   pw_tag;
    logic               sw_en;
    logic [INDEX_W-1:0] sw_idx;
    line_st_t           sw_st;
    logic [INDEX_W-1:0] snp_idx;
    logic [TAG_W-1:0]   snp_tag;
    logic               snoop_same;
    bus_cmd_t           cmd_e;
    line_st_t           res_e;

    assign snp_idx    = snoop_addr[INDEX_W-1:0];
    assign snp_tag    = snoop_addr[ADDR_W-1:INDEX_W];
    assign snoop_same = snoop_valid && (snp_idx == req_idx);
    assign bus_cmd    = cmd_e;
    assign cpu_state  = res_e;

    mesi_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .ra_idx (req_idx),
        .ra_st  (ra_st),
        .ra_tag (ra_tag),
        .rb_idx (snp_idx),
        .rb_st  (rb_st),
        .rb_tag (rb_tag),
        .pw_en  (pw_en),
        .pw_idx (req_idx),
        .pw_st  (pw_st),
        .pw_tag (pw_tag),
        .sw_en  (sw_en),
        .sw_idx (sw_idx),
        .sw_st  (sw_st)
    );

    mesi_snoop_resp #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_cmd   (bus_cmd_t'(snoop_cmd)),
        .snoop_tag   (snp_tag),
        .snoop_idx   (snp_idx),
        .line_st     (rb_st),
        .line_tag    (rb_tag),
        .flush       (snoop_flush),
        .shared      (snoop_shared),
        .sw_en       (sw_en),
        .sw_idx      (sw_idx),
        .sw_st       (sw_st)
    );

    mesi_req_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_req (
        .clk        (clk),
        .rst        (rst),
        .cpu_valid  (cpu_valid),
        .cpu_op     (cpu_op_t'(cpu_op)),
        .cpu_addr   (cpu_addr),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .cpu_state  (res_e),
        .bus_cmd    (cmd_e),
        .bus_addr   (bus_addr),
        .bus_gnt    (bus_gnt),
        .shared_in  (shared_in),
        .snoop_same (snoop_same),
        .req_idx    (req_idx),
        .line_st    (ra_st),
        .line_tag   (ra_tag),
        .pw_en      (pw_en),
        .pw_st      (pw_st),
        .pw_tag     (pw_tag)
    );

endmodule

// File: rtl/mesi_coherence_chk.sv
module mesi_coherence_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic [1:0]        cpu_op,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic [1:0]        cpu_state,
    input logic [2:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snoop_valid,
    input logic [2:0]        snoop_cmd,
    input logic              snoop_flush,
    input logic              snoop_shared
);

    logic [1:0] op_seen;

    always_ff @(posedge clk) begin
        if (rst)
            op_seen <= 2'd0;
        else if (cpu_valid && cpu_ready)
            op_seen <= cpu_op;
    end

    AST_READ_FILLS_VALID: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && op_seen == 2'd0) |-> (cpu_state != 2'd0));  // R2

    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> (bus_cmd == 3'd0));  // R3

    AST_WRITE_ENDS_MODIFIED: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && op_seen == 2'd1) |-> (cpu_state == 2'd3));  // R4

    AST_SHARED_ON_SNOOP_READ: assert property (@(posedge clk) disable iff (rst)
        snoop_shared |-> (snoop_valid && snoop_cmd == 3'd1));  // R5

    AST_FLUSH_ON_SNOOP: assert property (@(posedge clk) disable iff (rst)
        snoop_flush |-> (snoop_valid && snoop_cmd >= 3'd1 && snoop_cmd <= 3'd3));  // R6

    AST_REPLACE_ENDS_INVALID: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && op_seen == 2'd2) |-> (cpu_state == 2'd0));  // R7

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != 3'd0 && !bus_gnt && !snoop_valid)
        |=> ($stable(bus_cmd) && $stable(bus_addr)));  // R10

    AST_GNT_WITH_CMD: assert property (@(posedge clk) disable iff (rst)
        bus_gnt |-> (bus_cmd != 3'd0 && !snoop_valid));  // R10

endmodule

bind mesi_coherence_ctrl mesi_coherence_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_valid    (cpu_valid),
    .cpu_op       (cpu_op),
    .cpu_ready    (cpu_ready),
    .cpu_done     (cpu_done),
    .cpu_state    (cpu_state),
    .bus_cmd      (bus_cmd),
    .bus_addr     (bus_addr),
    .bus_gnt      (bus_gnt),
    .snoop_valid  (snoop_valid),
    .snoop_cmd    (snoop_cmd),
    .snoop_flush  (snoop_flush),
    .snoop_shared (snoop_shared)
);

// File: tb/sim_mesi_coherence_ctrl.sv
module sim_mesi_coherence_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        req_v  [2];
    logic [1:0]  req_op [2];
    logic [11:0] req_a  [2];
    logic        gnt    [2];
    logic        rdy    [2];
    logic        dn     [2];
    logic [1:0]  cst    [2];
    logic [2:0]  bcmd   [2];
    logic [11:0] baddr  [2];
    logic        sfl    [2];
    logic        ssh    [2];

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    mesi_coherence_ctrl u0 (
        .clk(clk), .rst(rst),
        .cpu_valid(req_v[0]), .cpu_op(req_op[0]), .cpu_addr(req_a[0]),
        .cpu_ready(rdy[0]), .cpu_done(dn[0]), .cpu_state(cst[0]),
        .bus_cmd(bcmd[0]), .bus_addr(baddr[0]), .bus_gnt(gnt[0]),
        .shared_in(ssh[1]),
        .snoop_valid(gnt[1]), .snoop_cmd(bcmd[1]), .snoop_addr(baddr[1]),
        .snoop_flush(sfl[0]), .snoop_shared(ssh[0])
    );

    mesi_coherence_ctrl u1 (
        .clk(clk), .rst(rst),
        .cpu_valid(req_v[1]), .cpu_op(req_op[1]), .cpu_addr(req_a[1]),
        .cpu_ready(rdy[1]), .cpu_done(dn[1]), .cpu_state(cst[1]),
        .bus_cmd(bcmd[1]), .bus_addr(baddr[1]), .bus_gnt(gnt[1]),
        .shared_in(ssh[0]),
        .snoop_valid(gnt[0]), .snoop_cmd(bcmd[0]), .snoop_addr(baddr[0]),
        .snoop_flush(sfl[1]), .snoop_shared(ssh[1])
    );

    typedef struct packed {
        logic        c;
        logic [1:0]  op;
        logic [11:0] a;
        logic [2:0]  cmd;
        logic [1:0]  n;
        logic [1:0]  st;
        logic        fl;
    } vec_t;

    // cache, op, addr, first cmd, cmd count, final state, other cache flushed
    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 12'h010, 3'd1, 2'd1, 2'd2, 1'b0},  // R2 miss alone -> E
        '{1'b0, 2'd1, 12'h010, 3'd0, 2'd0, 2'd3, 1'b0},  // R4 E write silent
        '{1'b0, 2'd0, 12'h010, 3'd0, 2'd0, 2'd3, 1'b0},  // R3 hit in M
        '{1'b1, 2'd0, 12'h010, 3'd1, 2'd1, 2'd1, 1'b1},  // R5 M flush, shared
        '{1'b0, 2'd0, 12'h010, 3'd0, 2'd0, 2'd1, 1'b0},  // R3 R5 now S
        '{1'b0, 2'd1, 12'h010, 3'd3, 2'd1, 2'd3, 1'b0},  // R4 upgrade
        '{1'b1, 2'd0, 12'h010, 3'd1, 2'd1, 2'd1, 1'b1},  // R6 other was I
        '{1'b1, 2'd1, 12'h010, 3'd3, 2'd1, 2'd3, 1'b0},  // R4 upgrade
        '{1'b0, 2'd1, 12'h010, 3'd2, 2'd1, 2'd3, 1'b1},  // R6 RdX flushes M
        '{1'b0, 2'd2, 12'h010, 3'd4, 2'd1, 2'd0, 1'b0},  // R7 write-back
        '{1'b1, 2'd0, 12'h010, 3'd1, 2'd1, 2'd2, 1'b0},  // R2 R9 nobody holds
        '{1'b1, 2'd2, 12'h010, 3'd0, 2'd0, 2'd0, 1'b0},  // R7 E replace silent
        '{1'b0, 2'd0, 12'h021, 3'd1, 2'd1, 2'd2, 1'b0},  // R2
        '{1'b0, 2'd1, 12'h021, 3'd0, 2'd0, 2'd3, 1'b0},  // R4
        '{1'b0, 2'd0, 12'h031, 3'd4, 2'd2, 2'd2, 1'b0},  // R8 dirty victim
        '{1'b0, 2'd0, 12'h021, 3'd1, 2'd1, 2'd2, 1'b0},  // R8 clean victim
        '{1'b1, 2'd0, 12'h055, 3'd1, 2'd1, 2'd2, 1'b0},  // R2
        '{1'b1, 2'd0, 12'h045, 3'd1, 2'd1, 2'd2, 1'b0},  // R8 clean victim
        '{1'b0, 2'd0, 12'h055, 3'd1, 2'd1, 2'd2, 1'b0}   // R9 tag mismatch
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic xact(input int c, input logic [1:0] op, input logic [11:0] a,
                        input int gdelay, input string req,
                        output logic [2:0] fc, output logic [11:0] fa,
                        output int n, output logic [1:0] fst, output logic ffl);
        int waited;
        logic [2:0]  pc;
        logic [11:0] pa;
        fc = 3'd0; fa = '0; n = 0; fst = 2'd0; ffl = 1'b0;
        waited = 0; pc = 3'd0; pa = '0;
        @(negedge clk);
        req_v[c] = 1'b1; req_op[c] = op; req_a[c] = a;
        @(negedge clk);
        req_v[c] = 1'b0;
        for (int k = 0; k < 60; k++) begin
            if (dn[c]) begin
                fst = cst[c];
                break;
            end
            if (bcmd[c] != 3'd0) begin
                if (waited > 0)
                    chk({req, " R10 held cmd"}, int'(bcmd[c]), int'(pc));
                if (waited > 0)
                    chk({req, " R10 held addr"}, int'(baddr[c]), int'(pa));
                pc = bcmd[c]; pa = baddr[c];
                if (waited < gdelay) begin
                    waited++;
                end else begin
                    if (n == 0) begin
                        fc = bcmd[c];
                        fa = baddr[c];
                    end
                    n++;
                    waited = 0;
                    gnt[c] = 1'b1;
                    #1;
                    if (sfl[1-c]) ffl = 1'b1;
                end
            end
            @(negedge clk);
            gnt[c] = 1'b0;
            #0.1;
        end
        if (!dn[c] && fst == 2'd0 && op != 2'd2)
            chk({req, " completion"}, 0, 1);
    endtask

    initial begin
        logic [2:0]  fc;
        logic [11:0] fa;
        int          n;
        logic [1:0]  fst;
        logic        ffl;
        for (int i = 0; i < 2; i++) begin
            req_v[i] = 1'b0; req_op[i] = 2'd0; req_a[i] = '0; gnt[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 2; i++) begin
            chk("R1 ready", int'(rdy[i]), 1);
            chk("R1 done", int'(dn[i]), 0);
            chk("R1 cmd", int'(bcmd[i]), 0);
        end
        // R1 a fresh cache misses on its first read
        xact(1, 2'd0, 12'h0F3, 0, "R1", fc, fa, n, fst, ffl);
        chk("R1 first read cmd", int'(fc), 1);
        xact(1, 2'd2, 12'h0F3, 0, "R7", fc, fa, n, fst, ffl);
        chk("R7 drop E", int'(n), 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("vec%0d", i);
            xact(int'(TBL[i].c), TBL[i].op, TBL[i].a, 0, tag, fc, fa, n, fst, ffl);
            chk({tag, " cmd"}, int'(fc), int'(TBL[i].cmd));
            chk({tag, " ncmd"}, n, int'(TBL[i].n));
            chk({tag, " state"}, int'(fst), int'(TBL[i].st));
            chk({tag, " flush"}, int'(ffl), int'(TBL[i].fl));
        end

        // R10: write miss with a slow grant keeps its command stable
        xact(0, 2'd1, 12'h077, 4, "R10", fc, fa, n, fst, ffl);
        chk("R10 cmd", int'(fc), 2);
        chk("R10 state", int'(fst), 3);
        // R8: dirty victim written back at its own address
        xact(0, 2'd0, 12'h087, 0, "R8", fc, fa, n, fst, ffl);
        chk("R8 victim cmd", int'(fc), 4);
        chk("R8 victim addr", int'(fa), 12'h077);
        chk("R8 total cmds", n, 2);
        // R7: replacing an absent line is silent
        xact(0, 2'd2, 12'h0A2, 0, "R7", fc, fa, n, fst, ffl);
        chk("R7 absent cmds", n, 0);
        chk("R7 absent state", int'(fst), 0);
        // R9: a write-back snooped by the other cache leaves its copy alone
        xact(1, 2'd0, 12'h0C4, 0, "R9", fc, fa, n, fst, ffl);
        xact(0, 2'd1, 12'h0C4, 0, "R9", fc, fa, n, fst, ffl);
        chk("R9 rdx", int'(fc), 2);
        xact(0, 2'd2, 12'h0C4, 0, "R9", fc, fa, n, fst, ffl);
        chk("R9 wb", int'(fc), 4);
        xact(1, 2'd0, 12'h0C4, 0, "R9", fc, fa, n, fst, ffl);
        chk("R9 after wb reread", int'(fc), 1);
        chk("R9 after wb state", int'(fst), 2);

        if (!ended) begin
            ended = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule